// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps a small bank of ownership tokens shared by two independent requesters, called left and right. Software on either side claims a shared resource by writing a 0 to the token that stands for it. It then reads the token back to learn whether the claim succeeded. Writing a 1 gives the token up. A claim made while the other side holds the token is not lost. It stays queued and takes effect on the cycle the holder lets go, so the waiting side never has to repeat its write.

Each side has a select, a write strobe, a read strobe, an address whose low bits pick one of the tokens, a single write-data bit and a registered read-data word. Every access finishes in the cycle it is presented, so there is no valid/ready pair and no back-pressure. A strobe is taken when select is high at a rising clock edge. A read returns its value one cycle later and holds it until the same side reads again. The token view is captured before any write in the same cycle takes effect.

Top module: `sem_bank`

## Requirements
- R1: The token is chosen by the low $clog2(NUM_SEM) address bits only. Any higher address bits do not change which token is accessed, and an access to one token leaves every other token unchanged.
- R2: A write (select and write strobe high) with data bit 0 requests the addressed token. With data bit 1 it releases the token or withdraws a queued request.
- R3: A read returns, on every data line, 0 when the reading side owns the token and 1 otherwise.
- R4: While one side owns a token, no write from the other side changes the owner, and a repeated request by the owner changes nothing.
- R5: When the owner releases a token that the other side has requested, either earlier or in the same cycle, ownership passes to the other side on that edge.
- R6: A release with no request queued from the other side leaves the token free. A free token reads all ones on both sides and queues no request.
- R7: Read data is registered when the read strobe is taken. It reflects the token state before any write in that same cycle, and it does not change until that side's next read.
- R8: When both sides request a free token in the same cycle, the left side becomes owner and the right side's request is queued.
- R9: After reset every token is free, nothing is queued, and both read-data words are all ones.
- R10: A queued request is cancelled if the requesting side writes 1 before it is granted, and a later release by the owner then frees the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sel | input | 1 | Left side token select |
| l_wr | input | 1 | Left side write strobe |
| l_rd | input | 1 | Left side read strobe |
| l_addr | input | ADDR_W | Left side address; low bits pick the token |
| l_wbit | input | 1 | Left write bit: 0 requests, 1 releases |
| l_rdata | output | DATA_W | Left registered token view, replicated |
| r_sel | input | 1 | Right side token select |
| r_wr | input | 1 | Right side write strobe |
| r_rd | input | 1 | Right side read strobe |
| r_addr | input | ADDR_W | Right side address; low bits pick the token |
| r_wbit | input | 1 | Right write bit: 0 requests, 1 releases |
| r_rdata | output | DATA_W | Right registered token view, replicated |

## Verification
For every token, the bench steps through all sequences of three cycles. In each cycle both sides pick one of three actions: idle, request or release. After each cycle it reads the token from both sides. This separates the cases of simultaneous claims on a free token, claims against a holder, a release with a request queued in the same cycle, and a release with a request queued earlier or withdrawn. Between tokens it reads the whole bank with the unused address bits changed, which shows whether the address decode confuses tokens or lets one token disturb another. Directed sequences cover the reset view and the plain request and release codes. They also cover a read taken in the same cycle as the other side's handover, which tells a registered capture apart from a live view.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_port_if.sv
module sem_port_if #(
  parameter  int NUM_SEM = 8,
  parameter  int ADDR_W  = 5,
  localparam int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wbit,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_idx
);
  logic [IDX_W-1:0] idx;
  logic             wr_en;

  assign idx    = addr[IDX_W-1:0];
  assign wr_en  = sel & wr;
  assign rd_en  = sel & rd;
  assign rd_idx = idx;

  generate
    for (genvar k = 0; k < NUM_SEM; k++) begin : g_dec
      logic hit;
      assign hit        = (idx == IDX_W'(k));
      assign req_vec[k] = wr_en & hit & ~wbit;
      assign rel_vec[k] = wr_en & hit &  wbit;
    end
    if (ADDR_W > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:IDX_W];
    end
  endgenerate

  AST_ONE_TOKEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec | rel_vec)); // R1
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_own,
  output logic r_own
);
  sem_owner_e owner_q, owner_d;
  logic       wait_l_q, wait_r_q;
  logic       want_l, want_r;

  // live claim: a new request, or a queued one not withdrawn this cycle
  assign want_l = l_req | (wait_l_q & ~l_rel);
  assign want_r = r_req | (wait_r_q & ~r_rel);

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      SEM_FREE: begin
        if (want_l)      owner_d = SEM_LEFT;
        else if (want_r) owner_d = SEM_RIGHT;
      end
      SEM_LEFT:  if (l_rel) owner_d = want_r ? SEM_RIGHT : SEM_FREE;
      SEM_RIGHT: if (r_rel) owner_d = want_l ? SEM_LEFT  : SEM_FREE;
      default:   owner_d = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= SEM_FREE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      wait_l_q <= (owner_d == SEM_RIGHT) & want_l;
      wait_r_q <= (owner_d == SEM_LEFT)  & want_r;
    end
  end

  assign l_own = (owner_q == SEM_LEFT);
  assign r_own = (owner_q == SEM_RIGHT);

  AST_HOLDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_LEFT && !l_rel) |=> (owner_q == SEM_LEFT)); // R4
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_LEFT && l_rel && (r_req || (wait_r_q && !r_rel))) |=> (owner_q == SEM_RIGHT)); // R5
  AST_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_FREE) |-> (!wait_l_q && !wait_r_q)); // R6
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_FREE && l_req && r_req) |=> (owner_q == SEM_LEFT && wait_r_q)); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == SEM_LEFT && wait_r_q && r_rel && !l_rel) |=> (owner_q == SEM_LEFT && !wait_r_q)); // R10
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
  parameter  int NUM_SEM = 8,
  parameter  int DATA_W  = 9,
  localparam int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]  rdata
);
  logic view_bit;

  assign view_bit = ~own_vec[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{view_bit}};
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R7
  AST_RD_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1)); // R3
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] l_own, r_own;
  logic               l_rd_en, r_rd_en;
  logic [IDX_W-1:0]   l_idx, r_idx;

  sem_port_if #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_left_if (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .wr(l_wr), .rd(l_rd),
    .addr(l_addr), .wbit(l_wbit), .req_vec(l_req), .rel_vec(l_rel),
    .rd_en(l_rd_en), .rd_idx(l_idx));

  sem_port_if #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_right_if (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .wr(r_wr), .rd(r_rd),
    .addr(r_addr), .wbit(r_wbit), .req_vec(r_req), .rel_vec(r_rel),
    .rd_en(r_rd_en), .rd_idx(r_idx));

  generate
    for (genvar k = 0; k < NUM_SEM; k++) begin : g_cell
      sem_cell u_cell (
        .clk(clk), .rst_n(rst_n),
        .l_req(l_req[k]), .l_rel(l_rel[k]),
        .r_req(r_req[k]), .r_rel(r_rel[k]),
        .l_own(l_own[k]), .r_own(r_own[k]));
    end
  endgenerate

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_left_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .rd_idx(l_idx),
    .own_vec(l_own), .rdata(l_rdata));

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_right_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .rd_idx(r_idx),
    .own_vec(r_own), .rdata(r_rdata));

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (l_own & r_own) == '0); // R4
endmodule

// File: tb/sem_bank_test.sv
module sem_bank_test;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_rd = 0, l_wbit = 0;
  logic r_sel = 0, r_wr = 0, r_rd = 0, r_wbit = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int total = 0;
  int bad = 0;
  int m_own [N];
  bit m_wl [N];
  bit m_wr [N];

  always #2 clk = ~clk;

  sem_bank #(.NUM_SEM(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata));

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 idle, 1 request (write 0), 2 release (write 1)
  function automatic void model_step(int i, int lop, int rop);
    bit wl, wr2;
    wl  = (lop == 1) || (m_wl[i] && lop != 2);
    wr2 = (rop == 1) || (m_wr[i] && rop != 2);
    case (m_own[i])
      0: if (wl) m_own[i] = 1; else if (wr2) m_own[i] = 2;
      1: if (lop == 2) m_own[i] = wr2 ? 2 : 0;
      default: if (rop == 2) m_own[i] = wl ? 1 : 0;
    endcase
    m_wl[i] = (m_own[i] == 2) && wl;
    m_wr[i] = (m_own[i] == 1) && wr2;
  endfunction

  function automatic logic [DW-1:0] view(int i, int side);
    return (m_own[i] == side) ? '0 : '1;
  endfunction

  task automatic idle_all();
    l_sel = 0; l_wr = 0; l_rd = 0; r_sel = 0; r_wr = 0; r_rd = 0;
  endtask

  task automatic do_ops(int i, int lop, int rop, int hi);
    l_addr = AW'((hi << 3) | i); r_addr = AW'(((hi ^ 3) << 3) | i);
    l_sel = (lop != 0); l_wr = (lop != 0); l_wbit = (lop == 2);
    r_sel = (rop != 0); r_wr = (rop != 0); r_wbit = (rop == 2);
    @(negedge clk);
    idle_all();
    model_step(i, lop, rop);
  endtask

  task automatic do_read(int i, int hi, string tag);
    l_addr = AW'((hi << 3) | i); r_addr = AW'((((hi + 1) & 3) << 3) | i);
    l_sel = 1; l_rd = 1; r_sel = 1; r_rd = 1;
    @(negedge clk);
    idle_all();
    check({tag, " left"},  l_rdata, view(i, 1));
    check({tag, " right"}, r_rdata, view(i, 2));
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_own[i] = 0; m_wl[i] = 0; m_wr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset view before any read
    check("R9 left reset", l_rdata, '1);
    check("R9 right reset", r_rdata, '1);
    for (int i = 0; i < N; i++) do_read(i, i & 3, "R9 R6 free after reset");

    // R2 and R3: plain request / release on token 5
    do_ops(5, 1, 0, 2);
    do_read(5, 1, "R2 R3 request");
    do_ops(5, 2, 0, 0);
    do_read(5, 3, "R2 R6 release");

    // R7: right reads in the same cycle as left hands over to right
    do_ops(2, 1, 0, 0);
    do_ops(2, 0, 1, 1);
    l_addr = AW'(2); l_sel = 1; l_wr = 1; l_wbit = 1;
    r_addr = AW'(2); r_sel = 1; r_rd = 1;
    @(negedge clk);
    idle_all();
    check("R7 pre-write capture", r_rdata, '1);
    model_step(2, 2, 0);
    repeat (3) @(negedge clk);
    check("R7 held value", r_rdata, '1);
    do_read(2, 2, "R5 granted after release");
    // R10: left queues, cancels, right releases -> free
    do_ops(2, 1, 0, 0);
    do_ops(2, 2, 0, 1);
    do_ops(2, 0, 2, 2);
    do_read(2, 0, "R10 cancel then free");

    // exhaustive three-step sweep per token
    for (int i = 0; i < N; i++) begin
      for (int n = 0; n < 729; n++) begin
        for (int s = 0; s < 3; s++) begin
          int pair, lop, rop, pre;
          string tag;
          pair = (s == 0) ? (n % 9) : (s == 1) ? ((n / 9) % 9) : (n / 81);
          lop = pair % 3; rop = pair / 3; pre = m_own[i];
          if (pre == 0 && lop == 1 && rop == 1) tag = "R8";
          else if (pre == 0) tag = "R6";
          else if ((pre == 1 && lop == 2) || (pre == 2 && rop == 2)) tag = "R5";
          else if ((pre == 1 && rop == 2 && m_wr[i]) || (pre == 2 && lop == 2 && m_wl[i])) tag = "R10";
          else tag = "R4";
          do_ops(i, lop, rop, (n + s) & 3);
          do_read(i, (n + s + 1) & 3, tag);
        end
      end
      for (int j = 0; j < N; j++) do_read(j, (i + j) & 3, "R1 bank scan");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule